// File: doc/BRIEF.md
# Committed-Instruction Trace Builder

This block sits beside the commit stage of an out-of-order core and groups consecutive committed instructions into traces for a value-reuse table. Each commit arrives with a decoded class tag and up to two source operands and one destination. Each source and the destination carry a register index and a value. Instructions whose class belongs to the active reuse domain are added to the open trace. The trace collects its live-in registers (read before any write inside the trace), its live-out registers (holding the last value written), a per-position branch bitmap with a taken bit for each branch, and the PC where it starts and the PC that follows it.

A trace closes when it would overflow its live-in or live-out slots, when it reaches its instruction or branch limit, or when an instruction outside the active domain commits. The closed entry is presented for one cycle on the emit outputs, which feed the table. A trace of a single instruction is also emitted. At run time the domain is selected as the full set of side-effect-free integer work, or as one subset (branches, add/subtract, address calculation), or as the full set minus that subset. The domain can only change while no trace is open.

Top module: `traceBuilder`

## Requirements
- R1: Class codes on `cmtClass` are 0 add/subtract, 1 other integer logic/arithmetic, 2 branch, 3 load/store address calculation, 4 memory access, 5 floating point, 6 system call, 7 other. Codes 4 to 7 never join a trace under any configuration.
- R2: The domain select takes the values 0 (full domain, classes 0 to 3), 1 (class 2 only), 2 (class 0 only) and 3 (class 3 only). With `cfgInvert` set and a select of 1 to 3, the domain is classes 0 to 3 minus that subset. With a select of 0, `cfgInvert` has no effect.
- R3: A `cfgWrite` takes effect for commits from the next cycle on. It is ignored while `traceOpen` is 1. A commit in the same cycle as the write uses the old domain.
- R4: An out-of-domain commit closes the open trace without joining it. If no trace is open, it causes no emission.
- R5: A source becomes a live-in only if its register is neither already a live-in nor written earlier in the trace. Its value is the value at that first read. Slots fill in order, source A before source B, and `emitLiMask` marks the filled slots.
- R6: Each distinct destination register takes one live-out slot, in order of its first write. The slot holds the last value written to that register, and `emitLoMask` marks the filled slots.
- R7: An in-domain instruction whose new live-ins or new live-out would exceed `LI_N` or `LO_N` closes the open trace and starts a new trace with itself.
- R8: When the `INSN_N`-th instruction joins a trace, the trace is emitted at once. `emitLen` gives the instruction count.
- R9: When the `BR_N`-th branch joins a trace, the trace is emitted at once.
- R10: Bit p of `emitBranchMap` is set when position p (0 = first instruction) is a branch. Bit p of `emitTakenMap` is set when that branch was taken.
- R11: `emitStartPc` is the PC of the first instruction. `emitNextPc` is the next-PC of the last instruction.
- R12: `emitValid` pulses for one cycle, in the cycle after the closing commit. A single-instruction trace is emitted like any other. `traceOpen` is 1 exactly while a trace holds instructions.
- R13: After reset no trace is open, nothing is emitted, and the domain is the full domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Load a new domain selection |
| cfgSel | input | 2 | Domain subset select |
| cfgInvert | input | 1 | Use the complement of the subset |
| cmtValid | input | 1 | An instruction commits this cycle |
| cmtPc | input | PC_W | PC of the committing instruction |
| cmtNextPc | input | PC_W | PC that follows it |
| cmtClass | input | 3 | Decoded class tag |
| cmtTaken | input | 1 | Branch outcome |
| srcAValid | input | 1 | Source A present |
| srcAIdx | input | REG_W | Source A register |
| srcAVal | input | DATA_W | Source A value |
| srcBValid | input | 1 | Source B present |
| srcBIdx | input | REG_W | Source B register |
| srcBVal | input | DATA_W | Source B value |
| dstValid | input | 1 | Destination present |
| dstIdx | input | REG_W | Destination register |
| dstVal | input | DATA_W | Value written |
| traceOpen | output | 1 | A trace is being built |
| emitValid | output | 1 | Closed trace on the emit outputs |
| emitStartPc | output | PC_W | First PC of the trace |
| emitNextPc | output | PC_W | PC after the trace |
| emitLen | output | clog2(INSN_N+1) | Instruction count |
| emitBranchMap | output | INSN_N | Branch positions |
| emitTakenMap | output | INSN_N | Taken branches |
| emitLiMask | output | LI_N | Filled live-in slots |
| emitLiIdx | output | LI_N*REG_W | Live-in registers, slot 0 lowest |
| emitLiVal | output | LI_N*DATA_W | Live-in values |
| emitLoMask | output | LO_N | Filled live-out slots |
| emitLoIdx | output | LO_N*REG_W | Live-out registers |
| emitLoVal | output | LO_N*DATA_W | Live-out values |

## Verification
Every combination of domain select and complement flag is swept. Under each one, a lone instruction of each of the eight classes is sent and then closed. This tells the class-to-domain mapping apart from the close-on-exclusion path. Directed sequences then fill live-ins, fill live-outs, reach the instruction and branch limits, and re-read or re-write a register already in the trace. Each sequence separates one termination cause or slot rule from the others. Long pseudo-random streams over a small register range, with configuration writes landing both while a trace is open and while none is, compare every emitted entry against an arithmetic model. This exposes ordering errors in slot filling and in the bitmaps.

// File: rtl/trcPkg.sv
package trcPkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADDSUB  = 3'd0,
    CLS_LOGIC   = 3'd1,
    CLS_BRANCH  = 3'd2,
    CLS_ADDR    = 3'd3,
    CLS_MEMACC  = 3'd4,
    CLS_FLOAT   = 3'd5,
    CLS_SYSCALL = 3'd6,
    CLS_OTHER   = 3'd7
  } instClass_e;

  // control -> datapath strobes
  typedef struct packed {
    logic emitCur;   // publish the trace as it stood before this commit
    logic emitAdded; // publish the trace including this commit, then empty it
    logic restart;   // start from an empty trace
    logic append;    // add the committing instruction
  } trcStrobe_t;
endpackage

// File: rtl/trcDomainFilter.sv
module trcDomainFilter
  import trcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [1:0]       cfgSel,
  input  logic             cfgInvert,
  input  logic             traceOpen,
  input  logic [CLS_W-1:0] cmtClass,
  output logic             eligible,
  output logic             isBranch
);
  logic [1:0] selQ;
  logic       invQ;
  logic [3:0] subsetMask;
  logic [3:0] domainMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= 2'd0;
      invQ <= 1'b0;
    end else if (cfgWrite && !traceOpen) begin
      selQ <= cfgSel;
      invQ <= cfgInvert;
    end
  end

  always_comb begin
    unique case (selQ)
      2'd0:    subsetMask = 4'b1111;
      2'd1:    subsetMask = 4'b0100;
      2'd2:    subsetMask = 4'b0001;
      default: subsetMask = 4'b1000;
    endcase
    domainMask = (invQ && selQ != 2'd0) ? (~subsetMask & 4'b1111) : subsetMask;
    eligible   = !cmtClass[2] && domainMask[cmtClass[1:0]];
    isBranch   = (cmtClass == CLS_BRANCH);
  end

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    (traceOpen && cfgWrite) |=> ($stable(selQ) && $stable(invQ)));
endmodule

// File: rtl/trcCtrl.sv
module trcCtrl
  import trcPkg::*;
#(
  parameter int LI_N   = 4,
  parameter int LO_N   = 4,
  parameter int INSN_N = 8,
  parameter int BR_N   = 2,
  localparam int LIC_W = $clog2(LI_N + 1),
  localparam int LOC_W = $clog2(LO_N + 1),
  localparam int INC_W = $clog2(INSN_N + 1),
  localparam int BRC_W = $clog2(BR_N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmtValid,
  input  logic             eligible,
  input  logic             isBranch,
  input  logic [INC_W-1:0] curLen,
  input  logic [BRC_W-1:0] curBr,
  input  logic [LIC_W-1:0] curLi,
  input  logic [LOC_W-1:0] curLo,
  input  logic [1:0]       newLi,
  input  logic             newLo,
  output trcStrobe_t       stb
);
  logic isOpen;
  logic overflow;
  int   lenAfter;
  int   brAfter;

  always_comb begin
    stb      = '0;
    isOpen   = (curLen != '0);
    overflow = isOpen && ((int'(curLi) + int'(newLi) > LI_N) ||
                          (int'(curLo) + int'(newLo) > LO_N));
    lenAfter = 0;
    brAfter  = 0;
    if (cmtValid) begin
      if (!eligible) begin
        if (isOpen) begin
          stb.emitCur = 1'b1;
          stb.restart = 1'b1;
        end
      end else begin
        stb.append = 1'b1;
        if (overflow) begin
          stb.emitCur = 1'b1;
          stb.restart = 1'b1;
          lenAfter    = 1;
          brAfter     = int'(isBranch);
        end else begin
          lenAfter = int'(curLen) + 1;
          brAfter  = int'(curBr) + int'(isBranch);
        end
        if (lenAfter == INSN_N || (isBranch && brAfter == BR_N))
          stb.emitAdded = 1'b1;
      end
    end
  end

  a_r7_single_emit_source: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.emitCur && stb.emitAdded));
  a_r4_excluded_never_joins: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && !eligible) |-> !stb.append);
endmodule

// File: rtl/trcDatapath.sv
module trcDatapath
  import trcPkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 16,
  parameter int REG_W  = 5,
  parameter int LI_N   = 4,
  parameter int LO_N   = 4,
  parameter int INSN_N = 8,
  parameter int BR_N   = 2,
  localparam int LIC_W = $clog2(LI_N + 1),
  localparam int LOC_W = $clog2(LO_N + 1),
  localparam int INC_W = $clog2(INSN_N + 1),
  localparam int BRC_W = $clog2(BR_N + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  trcStrobe_t               stb,
  input  logic [PC_W-1:0]          cmtPc,
  input  logic [PC_W-1:0]          cmtNextPc,
  input  logic                     isBranch,
  input  logic                     cmtTaken,
  input  logic                     srcAValid,
  input  logic [REG_W-1:0]         srcAIdx,
  input  logic [DATA_W-1:0]        srcAVal,
  input  logic                     srcBValid,
  input  logic [REG_W-1:0]         srcBIdx,
  input  logic [DATA_W-1:0]        srcBVal,
  input  logic                     dstValid,
  input  logic [REG_W-1:0]         dstIdx,
  input  logic [DATA_W-1:0]        dstVal,
  output logic [INC_W-1:0]         curLen,
  output logic [BRC_W-1:0]         curBr,
  output logic [LIC_W-1:0]         curLi,
  output logic [LOC_W-1:0]         curLo,
  output logic [1:0]               newLi,
  output logic                     newLo,
  output logic                     emitValid,
  output logic [PC_W-1:0]          emitStartPc,
  output logic [PC_W-1:0]          emitNextPc,
  output logic [INC_W-1:0]         emitLen,
  output logic [INSN_N-1:0]        emitBranchMap,
  output logic [INSN_N-1:0]        emitTakenMap,
  output logic [LI_N-1:0]          emitLiMask,
  output logic [LI_N*REG_W-1:0]    emitLiIdx,
  output logic [LI_N*DATA_W-1:0]   emitLiVal,
  output logic [LO_N-1:0]          emitLoMask,
  output logic [LO_N*REG_W-1:0]    emitLoIdx,
  output logic [LO_N*DATA_W-1:0]   emitLoVal
);
  // open trace
  logic [REG_W-1:0]  liIdx [LI_N];
  logic [DATA_W-1:0] liVal [LI_N];
  logic [REG_W-1:0]  loIdx [LO_N];
  logic [DATA_W-1:0] loVal [LO_N];
  logic [INSN_N-1:0] brMap, tkMap;
  logic [PC_W-1:0]   startPc, nextPc;

  // trace after this commit
  logic [REG_W-1:0]  nLiIdx [LI_N];
  logic [DATA_W-1:0] nLiVal [LI_N];
  logic [REG_W-1:0]  nLoIdx [LO_N];
  logic [DATA_W-1:0] nLoVal [LO_N];
  logic [LIC_W-1:0]  nLi;
  logic [LOC_W-1:0]  nLo;
  logic [INC_W-1:0]  nLen;
  logic [BRC_W-1:0]  nBr;
  logic [INSN_N-1:0] nBrMap, nTkMap;
  logic [PC_W-1:0]   nStartPc, nNextPc;

  // published entry
  logic [REG_W-1:0]  eLiIdx [LI_N];
  logic [DATA_W-1:0] eLiVal [LI_N];
  logic [REG_W-1:0]  eLoIdx [LO_N];
  logic [DATA_W-1:0] eLoVal [LO_N];
  logic [LIC_W-1:0]  eLi;
  logic [LOC_W-1:0]  eLo;

  logic aInLi, aInLo, bInLi, bInLo, newA, newB;
  logic gA, gB, gate;
  logic [LO_N-1:0] dstHitVec;

  // match the operands against the open trace
  always_comb begin
    aInLi = 1'b0; aInLo = 1'b0; bInLi = 1'b0; bInLo = 1'b0;
    dstHitVec = '0;
    for (int i = 0; i < LI_N; i++) begin
      if (LIC_W'(i) < curLi && liIdx[i] == srcAIdx) aInLi = 1'b1;
      if (LIC_W'(i) < curLi && liIdx[i] == srcBIdx) bInLi = 1'b1;
    end
    for (int j = 0; j < LO_N; j++) begin
      if (LOC_W'(j) < curLo && loIdx[j] == srcAIdx) aInLo = 1'b1;
      if (LOC_W'(j) < curLo && loIdx[j] == srcBIdx) bInLo = 1'b1;
      if (LOC_W'(j) < curLo && loIdx[j] == dstIdx)  dstHitVec[j] = 1'b1;
    end
    newA  = srcAValid && !aInLi && !aInLo;
    newB  = srcBValid && !bInLi && !bInLo && !(newA && srcBIdx == srcAIdx);
    newLi = {1'b0, newA} + {1'b0, newB};
    newLo = dstValid && (dstHitVec == '0);
  end

  // build the trace that results from this commit
  always_comb begin
    gate = !stb.restart;
    gA   = srcAValid && !(gate && (aInLi || aInLo));
    gB   = srcBValid && !(gate && (bInLi || bInLo)) && !(gA && srcBIdx == srcAIdx);
    for (int i = 0; i < LI_N; i++) begin
      nLiIdx[i] = gate ? liIdx[i] : '0;
      nLiVal[i] = gate ? liVal[i] : '0;
    end
    for (int j = 0; j < LO_N; j++) begin
      nLoIdx[j] = gate ? loIdx[j] : '0;
      nLoVal[j] = gate ? loVal[j] : '0;
    end
    nLi      = gate ? curLi   : '0;
    nLo      = gate ? curLo   : '0;
    nLen     = gate ? curLen  : '0;
    nBr      = gate ? curBr   : '0;
    nBrMap   = gate ? brMap   : '0;
    nTkMap   = gate ? tkMap   : '0;
    nStartPc = gate ? startPc : '0;
    nNextPc  = gate ? nextPc  : '0;
    if (stb.append) begin
      if (gA) begin
        for (int i = 0; i < LI_N; i++)
          if (LIC_W'(i) == nLi) begin nLiIdx[i] = srcAIdx; nLiVal[i] = srcAVal; end
        nLi = nLi + 1'b1;
      end
      if (gB) begin
        for (int i = 0; i < LI_N; i++)
          if (LIC_W'(i) == nLi) begin nLiIdx[i] = srcBIdx; nLiVal[i] = srcBVal; end
        nLi = nLi + 1'b1;
      end
      if (dstValid) begin
        if (gate && dstHitVec != '0) begin
          for (int j = 0; j < LO_N; j++)
            if (dstHitVec[j]) nLoVal[j] = dstVal;
        end else begin
          for (int j = 0; j < LO_N; j++)
            if (LOC_W'(j) == nLo) begin nLoIdx[j] = dstIdx; nLoVal[j] = dstVal; end
          nLo = nLo + 1'b1;
        end
      end
      for (int p = 0; p < INSN_N; p++)
        if (INC_W'(p) == nLen) begin
          nBrMap[p] = isBranch;
          nTkMap[p] = isBranch && cmtTaken;
        end
      if (nLen == '0) nStartPc = cmtPc;
      nNextPc = cmtNextPc;
      nLen    = nLen + 1'b1;
      nBr     = nBr + BRC_W'(isBranch);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.emitAdded) begin
      for (int i = 0; i < LI_N; i++) begin liIdx[i] <= '0; liVal[i] <= '0; end
      for (int j = 0; j < LO_N; j++) begin loIdx[j] <= '0; loVal[j] <= '0; end
      curLi <= '0; curLo <= '0; curLen <= '0; curBr <= '0;
      brMap <= '0; tkMap <= '0; startPc <= '0; nextPc <= '0;
    end else begin
      liIdx <= nLiIdx; liVal <= nLiVal; loIdx <= nLoIdx; loVal <= nLoVal;
      curLi <= nLi; curLo <= nLo; curLen <= nLen; curBr <= nBr;
      brMap <= nBrMap; tkMap <= nTkMap; startPc <= nStartPc; nextPc <= nNextPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emitValid <= 1'b0;
      for (int i = 0; i < LI_N; i++) begin eLiIdx[i] <= '0; eLiVal[i] <= '0; end
      for (int j = 0; j < LO_N; j++) begin eLoIdx[j] <= '0; eLoVal[j] <= '0; end
      eLi <= '0; eLo <= '0; emitLen <= '0;
      emitBranchMap <= '0; emitTakenMap <= '0; emitStartPc <= '0; emitNextPc <= '0;
    end else begin
      emitValid <= stb.emitCur || stb.emitAdded;
      if (stb.emitCur) begin
        eLiIdx <= liIdx; eLiVal <= liVal; eLoIdx <= loIdx; eLoVal <= loVal;
        eLi <= curLi; eLo <= curLo; emitLen <= curLen;
        emitBranchMap <= brMap; emitTakenMap <= tkMap;
        emitStartPc <= startPc; emitNextPc <= nextPc;
      end else if (stb.emitAdded) begin
        eLiIdx <= nLiIdx; eLiVal <= nLiVal; eLoIdx <= nLoIdx; eLoVal <= nLoVal;
        eLi <= nLi; eLo <= nLo; emitLen <= nLen;
        emitBranchMap <= nBrMap; emitTakenMap <= nTkMap;
        emitStartPc <= nStartPc; emitNextPc <= nNextPc;
      end
    end
  end

  for (genvar i = 0; i < LI_N; i++) begin : g_liOut
    assign emitLiIdx[i*REG_W +: REG_W]   = eLiIdx[i];
    assign emitLiVal[i*DATA_W +: DATA_W] = eLiVal[i];
    assign emitLiMask[i]                 = LIC_W'(i) < eLi;
  end
  for (genvar j = 0; j < LO_N; j++) begin : g_loOut
    assign emitLoIdx[j*REG_W +: REG_W]   = eLoIdx[j];
    assign emitLoVal[j*DATA_W +: DATA_W] = eLoVal[j];
    assign emitLoMask[j]                 = LOC_W'(j) < eLo;
  end

  a_r8_len_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    curLen < INC_W'(INSN_N));
  a_r9_branches_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    curBr < BRC_W'(BR_N));
  a_r5_li_within_slots: assert property (@(posedge clk) disable iff (!rstN)
    curLi <= LIC_W'(LI_N));
  a_r6_lo_within_slots: assert property (@(posedge clk) disable iff (!rstN)
    curLo <= LOC_W'(LO_N));
  a_r12_no_empty_emit: assert property (@(posedge clk) disable iff (!rstN)
    emitValid |-> emitLen != '0);
  a_r10_taken_only_on_branch: assert property (@(posedge clk) disable iff (!rstN)
    emitValid |-> ((emitTakenMap & ~emitBranchMap) == '0));
endmodule

// File: rtl/traceBuilder.sv
module traceBuilder
  import trcPkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 16,
  parameter int REG_W  = 5,
  parameter int LI_N   = 4,
  parameter int LO_N   = 4,
  parameter int INSN_N = 8,
  parameter int BR_N   = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrite,
  input  logic [1:0]                  cfgSel,
  input  logic                        cfgInvert,
  input  logic                        cmtValid,
  input  logic [PC_W-1:0]             cmtPc,
  input  logic [PC_W-1:0]             cmtNextPc,
  input  logic [2:0]                  cmtClass,
  input  logic                        cmtTaken,
  input  logic                        srcAValid,
  input  logic [REG_W-1:0]            srcAIdx,
  input  logic [DATA_W-1:0]           srcAVal,
  input  logic                        srcBValid,
  input  logic [REG_W-1:0]            srcBIdx,
  input  logic [DATA_W-1:0]           srcBVal,
  input  logic                        dstValid,
  input  logic [REG_W-1:0]            dstIdx,
  input  logic [DATA_W-1:0]           dstVal,
  output logic                        traceOpen,
  output logic                        emitValid,
  output logic [PC_W-1:0]             emitStartPc,
  output logic [PC_W-1:0]             emitNextPc,
  output logic [$clog2(INSN_N+1)-1:0] emitLen,
  output logic [INSN_N-1:0]           emitBranchMap,
  output logic [INSN_N-1:0]           emitTakenMap,
  output logic [LI_N-1:0]             emitLiMask,
  output logic [LI_N*REG_W-1:0]       emitLiIdx,
  output logic [LI_N*DATA_W-1:0]      emitLiVal,
  output logic [LO_N-1:0]             emitLoMask,
  output logic [LO_N*REG_W-1:0]       emitLoIdx,
  output logic [LO_N*DATA_W-1:0]      emitLoVal
);
  localparam int LIC_W = $clog2(LI_N + 1);
  localparam int LOC_W = $clog2(LO_N + 1);
  localparam int INC_W = $clog2(INSN_N + 1);
  localparam int BRC_W = $clog2(BR_N + 1);

  logic             eligible, isBranch, newLo;
  logic [1:0]       newLi;
  logic [INC_W-1:0] curLen;
  logic [BRC_W-1:0] curBr;
  logic [LIC_W-1:0] curLi;
  logic [LOC_W-1:0] curLo;
  trcStrobe_t       stb;

  assign traceOpen = (curLen != '0);

  trcDomainFilter u_filter (
    .clk, .rstN, .cfgWrite, .cfgSel, .cfgInvert, .traceOpen,
    .cmtClass, .eligible, .isBranch
  );

  trcCtrl #(.LI_N(LI_N), .LO_N(LO_N), .INSN_N(INSN_N), .BR_N(BR_N)) u_ctrl (
    .clk, .rstN, .cmtValid, .eligible, .isBranch,
    .curLen, .curBr, .curLi, .curLo, .newLi, .newLo, .stb
  );

  trcDatapath #(
    .PC_W(PC_W), .DATA_W(DATA_W), .REG_W(REG_W),
    .LI_N(LI_N), .LO_N(LO_N), .INSN_N(INSN_N), .BR_N(BR_N)
  ) u_dp (
    .clk, .rstN, .stb, .cmtPc, .cmtNextPc, .isBranch, .cmtTaken,
    .srcAValid, .srcAIdx, .srcAVal, .srcBValid, .srcBIdx, .srcBVal,
    .dstValid, .dstIdx, .dstVal,
    .curLen, .curBr, .curLi, .curLo, .newLi, .newLo,
    .emitValid, .emitStartPc, .emitNextPc, .emitLen,
    .emitBranchMap, .emitTakenMap,
    .emitLiMask, .emitLiIdx, .emitLiVal,
    .emitLoMask, .emitLoIdx, .emitLoVal
  );

  a_r13_idle_after_reset: assert property (@(posedge clk)
    $past(!rstN) |-> (!emitValid && !traceOpen));
endmodule

// File: tb/test_traceBuilder.sv
module test_traceBuilder;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 16, DW = 16, RW = 5, NLI = 4, NLO = 4, NINS = 8, NBR = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 0, cfgInvert = 0, cmtValid = 0, cmtTaken = 0;
  logic [1:0] cfgSel = 0;
  logic [PCW-1:0] cmtPc = 0, cmtNextPc = 0;
  logic [2:0] cmtClass = 0;
  logic srcAValid = 0, srcBValid = 0, dstValid = 0;
  logic [RW-1:0] srcAIdx = 0, srcBIdx = 0, dstIdx = 0;
  logic [DW-1:0] srcAVal = 0, srcBVal = 0, dstVal = 0;
  logic traceOpen, emitValid;
  logic [PCW-1:0] emitStartPc, emitNextPc;
  logic [3:0] emitLen;
  logic [NINS-1:0] emitBranchMap, emitTakenMap;
  logic [NLI-1:0] emitLiMask;
  logic [NLI*RW-1:0] emitLiIdx;
  logic [NLI*DW-1:0] emitLiVal;
  logic [NLO-1:0] emitLoMask;
  logic [NLO*RW-1:0] emitLoIdx;
  logic [NLO*DW-1:0] emitLoVal;

  always #(CLK_PERIOD/2) clk = ~clk;

  traceBuilder i_traceBuilder (.*);

  int errors = 0, checks = 0;
  logic [PCW-1:0] pcReg = 16'h0100;

  // arithmetic model state
  int mSel = 0, mInv = 0;
  int mLen = 0, mBr = 0, mLiN = 0, mLoN = 0;
  int mLiIdx[NLI], mLiVal[NLI], mLoIdx[NLO], mLoVal[NLO];
  logic [NINS-1:0] mBrMap = 0, mTk = 0;
  logic [PCW-1:0] mStart = 0, mNext = 0;
  // expected outputs
  logic eValid = 0, eOpen = 0;
  logic [PCW-1:0] eStart = 0, eNext = 0;
  int eLen = 0;
  logic [NINS-1:0] eBr = 0, eTk = 0;
  logic [NLI-1:0] eLiM = 0; logic [NLO-1:0] eLoM = 0;
  logic [NLI*RW-1:0] eLiI = 0; logic [NLO*RW-1:0] eLoI = 0;
  logic [NLI*DW-1:0] eLiV = 0; logic [NLO*DW-1:0] eLoV = 0;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic inDomain(input int cls, input int sel, input int inv);
    logic m;
    if (cls >= 4) return 1'b0;
    if (sel == 0) return 1'b1;
    m = (sel == 1) ? (cls == 2) : (sel == 2) ? (cls == 0) : (cls == 3);
    return inv ? !m : m;
  endfunction

  function automatic logic liHas(input int r);
    for (int i = 0; i < mLiN; i++) if (mLiIdx[i] == r) return 1'b1;
    return 1'b0;
  endfunction
  function automatic int loFind(input int r);
    for (int j = 0; j < mLoN; j++) if (mLoIdx[j] == r) return j;
    return -1;
  endfunction

  task automatic clearModel();
    mLen = 0; mBr = 0; mLiN = 0; mLoN = 0; mBrMap = 0; mTk = 0;
  endtask

  task automatic snapshot();
    eValid = 1; eLen = mLen; eStart = mStart; eNext = mNext; eBr = mBrMap; eTk = mTk;
    eLiM = 0; eLoM = 0; eLiI = 0; eLoI = 0; eLiV = 0; eLoV = 0;
    for (int i = 0; i < mLiN; i++) begin
      eLiM[i] = 1; eLiI[i*RW +: RW] = RW'(mLiIdx[i]); eLiV[i*DW +: DW] = DW'(mLiVal[i]);
    end
    for (int j = 0; j < mLoN; j++) begin
      eLoM[j] = 1; eLoI[j*RW +: RW] = RW'(mLoIdx[j]); eLoV[j*DW +: DW] = DW'(mLoVal[j]);
    end
  endtask

  task automatic modelStep();
    logic open0, aN, bN, oN, br;
    int k;
    eValid = 0;
    open0 = (mLen != 0);
    if (cmtValid) begin
      br = (cmtClass == 3'd2);
      if (!inDomain(int'(cmtClass), mSel, mInv)) begin
        if (open0) begin snapshot(); clearModel(); end
      end else begin
        aN = srcAValid && !liHas(int'(srcAIdx)) && loFind(int'(srcAIdx)) < 0;
        bN = srcBValid && !liHas(int'(srcBIdx)) && loFind(int'(srcBIdx)) < 0 &&
             !(aN && srcBIdx == srcAIdx);
        oN = dstValid && loFind(int'(dstIdx)) < 0;
        if (open0 && (mLiN + int'(aN) + int'(bN) > NLI || mLoN + int'(oN) > NLO)) begin
          snapshot(); clearModel();
        end
        if (srcAValid && !liHas(int'(srcAIdx)) && loFind(int'(srcAIdx)) < 0) begin
          mLiIdx[mLiN] = int'(srcAIdx); mLiVal[mLiN] = int'(srcAVal); mLiN++;
        end
        if (srcBValid && !liHas(int'(srcBIdx)) && loFind(int'(srcBIdx)) < 0) begin
          mLiIdx[mLiN] = int'(srcBIdx); mLiVal[mLiN] = int'(srcBVal); mLiN++;
        end
        if (dstValid) begin
          k = loFind(int'(dstIdx));
          if (k >= 0) mLoVal[k] = int'(dstVal);
          else begin mLoIdx[mLoN] = int'(dstIdx); mLoVal[mLoN] = int'(dstVal); mLoN++; end
        end
        if (mLen == 0) mStart = cmtPc;
        mNext = cmtNextPc;
        mBrMap[mLen] = br; mTk[mLen] = br && cmtTaken;
        mLen++; mBr += int'(br);
        if (mLen == NINS || (br && mBr == NBR)) begin snapshot(); clearModel(); end
      end
    end
    if (cfgWrite && !open0) begin mSel = int'(cfgSel); mInv = int'(cfgInvert); end
    eOpen = (mLen != 0);
  endtask

  // drive at negedge, model, clock, sample at the next negedge
  task automatic step(input string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check(emitValid == eValid, "R4", {tag, " emitValid"}, 64'(emitValid), 64'(eValid));
    check(traceOpen == eOpen, "R12", {tag, " traceOpen"}, 64'(traceOpen), 64'(eOpen));
    if (eValid && emitValid) begin
      check(emitLen == 4'(eLen), "R8", {tag, " length"}, 64'(emitLen), 64'(eLen));
      check(emitStartPc == eStart && emitNextPc == eNext, "R11", {tag, " pcs"},
            {32'(emitStartPc), 32'(emitNextPc)}, {32'(eStart), 32'(eNext)});
      check(emitBranchMap == eBr && emitTakenMap == eTk, "R10", {tag, " maps"},
            {32'(emitBranchMap), 32'(emitTakenMap)}, {32'(eBr), 32'(eTk)});
      check(emitLiMask == eLiM && emitLiIdx == eLiI && emitLiVal == eLiV, "R5",
            {tag, " live-ins"}, emitLiVal, eLiV);
      check(emitLiMask == eLiM && emitLiIdx == eLiI, "R5", {tag, " live-in regs"},
            {44'(emitLiIdx), 4'(emitLiMask)}, {44'(eLiI), 4'(eLiM)});
      check(emitLoMask == eLoM && emitLoIdx == eLoI && emitLoVal == eLoV, "R6",
            {tag, " live-outs"}, emitLoVal, eLoV);
      check(emitLoMask == eLoM && emitLoIdx == eLoI, "R6", {tag, " live-out regs"},
            {44'(emitLoIdx), 4'(emitLoMask)}, {44'(eLoI), 4'(eLoM)});
    end
    cmtValid = 0; cfgWrite = 0;
  endtask

  task automatic setIns(input int cls, input logic tk,
                        input logic av, input int ai, input int avl,
                        input logic bv, input int bi, input int bvl,
                        input logic dv, input int di, input int dvl);
    cmtValid = 1; cmtClass = 3'(cls); cmtTaken = tk; cmtPc = pcReg;
    cmtNextPc = (cls == 2 && tk) ? pcReg + 16'h0040 : pcReg + 16'h0004;
    pcReg = cmtNextPc;
    srcAValid = av; srcAIdx = RW'(ai); srcAVal = DW'(avl);
    srcBValid = bv; srcBIdx = RW'(bi); srcBVal = DW'(bvl);
    dstValid = dv; dstIdx = RW'(di); dstVal = DW'(dvl);
  endtask

  task automatic ins(input string tag, input int cls, input logic tk,
                     input logic av, input int ai, input int avl,
                     input logic bv, input int bi, input int bvl,
                     input logic dv, input int di, input int dvl);
    setIns(cls, tk, av, ai, avl, bv, bi, bvl, dv, di, dvl);
    step(tag);
  endtask

  task automatic plain(input string tag, input int cls);
    ins(tag, cls, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cfg(input int sel, input int inv);
    cfgWrite = 1; cfgSel = 2'(sel); cfgInvert = inv[0];
    step("cfg");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R13: reset state
    repeat (3) @(negedge clk);
    check(!emitValid && !traceOpen, "R13", "in reset", {emitValid, traceOpen}, 0);
    rstN = 1;
    @(negedge clk);
    check(!emitValid && !traceOpen, "R13", "after reset", {emitValid, traceOpen}, 0);
    // R13: full domain by default, class 1 joins
    plain("R13 default domain", 1);
    check(traceOpen == 1'b1, "R13", "logic op joins default domain", 64'(traceOpen), 1);
    plain("R12 single close", 6);
    check(emitValid && emitLen == 1, "R12", "single-instruction trace", 64'(emitLen), 1);

    // R5 R6: re-read after write, rewrite, same reg on both sources
    ins("R5 first", 0, 0, 1, 3, 11, 1, 3, 11, 1, 3, 20);
    ins("R5 reread", 1, 0, 1, 3, 20, 1, 4, 7, 1, 3, 21);
    ins("R6 rewrite", 0, 0, 1, 4, 7, 0, 0, 0, 1, 5, 30);
    plain("R6 close", 5);
    check(emitLiMask == 4'b0011, "R5", "two live-ins", 64'(emitLiMask), 64'(4'b0011));
    check(emitLoVal[15:0] == 16'd21, "R6", "last value kept", 64'(emitLoVal[15:0]), 21);

    // R7: live-in overflow
    ins("R7 a", 0, 0, 1, 1, 1, 1, 2, 2, 0, 0, 0);
    ins("R7 b", 0, 0, 1, 3, 3, 1, 4, 4, 0, 0, 0);
    ins("R7 c", 0, 0, 1, 5, 5, 0, 0, 0, 0, 0, 0);
    check(emitValid && emitLen == 2 && traceOpen, "R7", "li overflow split",
          {emitLen, traceOpen}, {4'd2, 1'b1});
    plain("R7 close", 7);
    // R7: live-out overflow
    for (int r = 1; r <= 5; r++) ins("R7 lo", 1, 0, 0, 0, 0, 0, 0, 0, 1, r, r * 3);
    check(emitValid && emitLen == 4, "R7", "lo overflow split", 64'(emitLen), 4);
    plain("R7 close2", 5);

    // R8: instruction limit
    for (int n = 0; n < NINS; n++) plain("R8 fill", n % 2);
    check(emitValid && emitLen == 4'(NINS) && !traceOpen, "R8", "length limit",
          64'(emitLen), 64'(NINS));
    // R9: branch limit, R10 maps
    plain("R9 alu", 0);
    ins("R9 br1", 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    ins("R9 br2", 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check(emitValid && emitBranchMap == 8'b110 && emitTakenMap == 8'b010, "R9",
          "branch limit maps", {emitBranchMap, emitTakenMap}, {8'b110, 8'b010});

    // R3: config write while open is ignored
    plain("R3 open", 0);
    cfgWrite = 1; cfgSel = 2'd1; cfgInvert = 0; step("R3 locked write");
    plain("R3 still full", 1);
    check(traceOpen && !emitValid, "R3", "logic op still joins", 64'(traceOpen), 1);
    plain("R3 close", 4);

    // R1 R2: sweep every configuration and class
    for (int sel = 0; sel < 4; sel++)
      for (int inv = 0; inv < 2; inv++) begin
        plain("R4 flush", 5);
        cfg(sel, inv);
        for (int c = 0; c < 8; c++) begin
          plain(c >= 4 ? "R1 class" : "R2 class", c);
          check(traceOpen == inDomain(c, sel, inv), c >= 4 ? "R1" : "R2", "eligibility",
                64'(traceOpen), 64'(inDomain(c, sel, inv)));
          plain("R4 close", 5);
        end
        // pseudo-random stream under this configuration
        for (int n = 0; n < 250; n++) begin
          int cls;
          cls = ($urandom % 10 < 8) ? int'($urandom % 4) : 4 + int'($urandom % 4);
          if ($urandom % 25 == 0) begin
            cfgWrite = 1; cfgSel = 2'($urandom); cfgInvert = 1'($urandom);
          end
          setIns(cls, 1'($urandom), 1'($urandom), int'($urandom % 7), int'($urandom % 64),
                 1'($urandom), int'($urandom % 7), int'($urandom % 64),
                 1'($urandom), int'($urandom % 7), int'($urandom % 64));
          step("R10 R11 random");
        end
        plain("R4 flush", 5);
        cfgWrite = 1; cfgSel = 2'(sel); cfgInvert = inv[0]; step("cfg restore");
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule